// File: doc/BRIEF.md
# Four-Channel Double-Buffered Output Register Bank

This block sits behind a serial command receiver that has already framed and decoded a write. Each frame delivers a two-bit load code, a two-bit channel select, a power-down flag and a 16-bit payload, along with a one-cycle valid strobe. Every channel has two registers. The staging register holds a prepared value. The live register drives the converter. Either register can hold a plain output code or a power-down request.

The load code decides where the frame's value goes. Code 00 stages the value for one channel only. Code 01 stages it and also makes it live on that channel. Code 10 makes the value live on the selected channel, and at the same moment every other channel promotes its staged entry. Code 11 applies to all channels: it either promotes every staged entry and ignores the payload, or it writes the payload to every channel. A power-down request leaves a register's stored code in place, so the channel returns to that code once a later data load clears the power-down.

Top module: `dac_regbank`

## Requirements
- R1: While reset is asserted, every output code is 0, every power-down enable is 0 and every power-down mode is 00. All registers stay in this state until a load that targets them arrives.
- R2: Load code 00 writes only the staging register of the channel given by the select field (00 = channel 0 through 11 = channel 3). No output changes.
- R3: Load code 01 writes the selected channel's staging and live registers. Its outputs show the new value after the clock edge on which the valid strobe is sampled. The other channels' outputs do not change.
- R4: Load code 10 writes the new value into the selected channel's staging and live registers. On the same edge, the live register of every other channel takes that channel's staged entry.
- R5: Load code 11 with select bit 1 (the upper select bit) equal to 0 ignores the payload. Every channel's live register takes its staged entry.
- R6: Load code 11 with select bit 1 equal to 1 writes the frame's value into the staging and live registers of all four channels.
- R7: When the power-down flag is 1, payload bits 15..14 are the mode (00 high impedance, 01 about 1 kΩ to ground, 10 about 100 kΩ to ground, 11 high impedance). The target register sets its power-down enable, takes that mode and keeps its previous code.
- R8: A data write (flag 0) clears power-down and sets the mode to 00. The code takes all 16 payload bits.
- R9: A staged power-down request is promoted in the same way as staged data. One promotion can leave some channels powered down and others driving new codes.
- R10: On a cycle without the valid strobe, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_vld | input | 1 | One-cycle strobe: a decoded frame is present |
| ld_code | input | 2 | Load code |
| ch_sel | input | 2 | Channel select; bit 1 also picks the form of broadcast |
| pd_flag | input | 1 | 1 = payload bits 15..14 carry a power-down mode |
| payload | input | 16 | Output code, or mode in bits 15..14 |
| out_code | output | 64 | Live codes, channel n in bits 16n+15..16n |
| out_pd_en | output | 4 | Live power-down enable, bit n for channel n |
| out_pd_mode | output | 8 | Live power-down mode, channel n in bits 2n+1..2n |

## Verification
Several behaviours are checked on every cycle. Outputs hold when no frame arrives or when a frame only stages a value. A single-channel commit leaves the other channels alone and lands its data or mode exactly one edge later. A data broadcast reaches all four outputs. Raising power-down never disturbs a channel's code. The staging registers are not visible at the ports, so only the bench's scripted frame sequence can show that staged values, including a mix of power-down and data, come out correctly on a later promotion.

// File: rtl/dac_regbank.sv
module dac_regbank #(
  parameter int CODE_W = 16,
  parameter int NCH    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frm_vld,
  input  logic [1:0]            ld_code,
  input  logic [1:0]            ch_sel,
  input  logic                  pd_flag,
  input  logic [CODE_W-1:0]     payload,
  output logic [NCH*CODE_W-1:0] out_code,
  output logic [NCH-1:0]        out_pd_en,
  output logic [NCH*2-1:0]      out_pd_mode
);
  localparam int SEL_W = 2;

  typedef struct packed {
    logic              pd;
    logic [1:0]        mode;
    logic [CODE_W-1:0] code;
  } ent_t;

  function automatic ent_t merge(ent_t dst, ent_t src);
    merge = src.pd ? '{pd: 1'b1, mode: src.mode, code: dst.code}
                   : '{pd: 1'b0, mode: 2'b00, code: src.code};
  endfunction

  ent_t new_e;
  assign new_e = '{pd: pd_flag, mode: payload[CODE_W-1 -: 2], code: payload};

  logic all_ld, bc_data, bc_prom;
  assign all_ld  = (ld_code == 2'b11);
  assign bc_data = all_ld &  ch_sel[SEL_W-1];
  assign bc_prom = all_ld & ~ch_sel[SEL_W-1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    ent_t tmp_q, act_q;
    logic hit, wr_tmp, wr_act, prom;

    assign hit    = (ch_sel == SEL_W'(i));
    assign wr_tmp = frm_vld & ((~all_ld & hit) | bc_data);
    assign wr_act = frm_vld & (((ld_code == 2'b01 || ld_code == 2'b10) & hit) | bc_data);
    assign prom   = frm_vld & (((ld_code == 2'b10) & ~hit) | bc_prom);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tmp_q <= '0;
        act_q <= '0;
      end else begin
        if (wr_tmp) tmp_q <= merge(tmp_q, new_e);
        if (wr_act)    act_q <= merge(act_q, new_e);
        else if (prom) act_q <= merge(act_q, tmp_q);
      end
    end

    assign out_code[i*CODE_W +: CODE_W] = act_q.code;
    assign out_pd_en[i]                 = act_q.pd;
    assign out_pd_mode[i*2 +: 2]        = act_q.mode;
  end
endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk #(
  parameter int CODE_W = 16,
  parameter int NCH    = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  frm_vld,
  input logic [1:0]            ld_code,
  input logic [1:0]            ch_sel,
  input logic                  pd_flag,
  input logic [CODE_W-1:0]     payload,
  input logic [NCH*CODE_W-1:0] out_code,
  input logic [NCH-1:0]        out_pd_en,
  input logic [NCH*2-1:0]      out_pd_mode
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (out_code == '0 && out_pd_en == '0 && out_pd_mode == '0)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> ($stable(out_code) && $stable(out_pd_en) && $stable(out_pd_mode))); // R10

  AST_STAGE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && ld_code == 2'b00) |=> ($stable(out_code) && $stable(out_pd_en) && $stable(out_pd_mode))); // R2

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_SINGLE_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && ld_code == 2'b01 && ch_sel != 2'(i)) |=>
      ($stable(out_code[i*CODE_W +: CODE_W]) && $stable(out_pd_en[i]) && $stable(out_pd_mode[i*2 +: 2]))); // R3

    AST_SINGLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && ld_code == 2'b01 && ch_sel == 2'(i) && !pd_flag) |=>
      (out_code[i*CODE_W +: CODE_W] == $past(payload) && !out_pd_en[i] && out_pd_mode[i*2 +: 2] == 2'b00)); // R8

    AST_SINGLE_PD: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && ld_code == 2'b01 && ch_sel == 2'(i) && pd_flag) |=>
      (out_pd_en[i] && out_pd_mode[i*2 +: 2] == $past(payload[CODE_W-1 -: 2]))); // R7

    AST_PD_KEEPS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_pd_en[i]) |-> $stable(out_code[i*CODE_W +: CODE_W])); // R7

    AST_BCAST_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && ld_code == 2'b11 && ch_sel[1] && !pd_flag) |=>
      (out_code[i*CODE_W +: CODE_W] == $past(payload) && !out_pd_en[i])); // R6
  end
endmodule

bind dac_regbank dac_regbank_chk #(.CODE_W(CODE_W), .NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .ld_code(ld_code), .ch_sel(ch_sel),
  .pd_flag(pd_flag), .payload(payload), .out_code(out_code), .out_pd_en(out_pd_en),
  .out_pd_mode(out_pd_mode)
);

// File: tb/dac_regbank_tb_top.sv
module dac_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_vld = 1'b0;
  logic [1:0]  ld_code = '0;
  logic [1:0]  ch_sel = '0;
  logic        pd_flag = 1'b0;
  logic [15:0] payload = '0;
  logic [63:0] out_code;
  logic [3:0]  out_pd_en;
  logic [7:0]  out_pd_mode;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dac_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .ld_code(ld_code), .ch_sel(ch_sel),
    .pd_flag(pd_flag), .payload(payload), .out_code(out_code), .out_pd_en(out_pd_en),
    .out_pd_mode(out_pd_mode)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  ld;
    logic [1:0]  sel;
    logic        pd;
    logic [15:0] pay;
    logic [63:0] e_code;
    logic [3:0]  e_pd;
    logic [7:0]  e_mode;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 2'b01, 2'd0, 1'b0, 16'h1111, 64'h0000_0000_0000_1111, 4'b0000, 8'h00}, // R3
    '{4'd2, 2'b00, 2'd1, 1'b0, 16'h2222, 64'h0000_0000_0000_1111, 4'b0000, 8'h00}, // R2
    '{4'd2, 2'b00, 2'd2, 1'b1, 16'h4000, 64'h0000_0000_0000_1111, 4'b0000, 8'h00}, // R2
    '{4'd4, 2'b10, 2'd3, 1'b0, 16'h4444, 64'h4444_0000_2222_1111, 4'b0100, 8'h10}, // R4 R9
    '{4'd7, 2'b01, 2'd0, 1'b1, 16'h8000, 64'h4444_0000_2222_1111, 4'b0101, 8'h12}, // R7
    '{4'd2, 2'b00, 2'd2, 1'b0, 16'h3333, 64'h4444_0000_2222_1111, 4'b0101, 8'h12}, // R2
    '{4'd5, 2'b11, 2'd0, 1'b0, 16'hABCD, 64'h4444_3333_2222_1111, 4'b0001, 8'h02}, // R5 R9
    '{4'd6, 2'b11, 2'd2, 1'b0, 16'h5A5A, 64'h5A5A_5A5A_5A5A_5A5A, 4'b0000, 8'h00}, // R6
    '{4'd7, 2'b11, 2'd3, 1'b1, 16'hC000, 64'h5A5A_5A5A_5A5A_5A5A, 4'b1111, 8'hFF}, // R7 R6
    '{4'd8, 2'b01, 2'd1, 1'b0, 16'h0001, 64'h5A5A_5A5A_0001_5A5A, 4'b1101, 8'hF3}, // R8
    '{4'd9, 2'b10, 2'd0, 1'b0, 16'hFFFF, 64'h5A5A_5A5A_0001_FFFF, 4'b1100, 8'hF0}, // R9 R4
    '{4'd2, 2'b00, 2'd3, 1'b0, 16'h7777, 64'h5A5A_5A5A_0001_FFFF, 4'b1100, 8'hF0}, // R2
    '{4'd5, 2'b11, 2'd1, 1'b0, 16'h9999, 64'h7777_5A5A_0001_FFFF, 4'b0100, 8'h30}  // R5
  };

  task automatic check_out(input int req, input logic [63:0] ec, input logic [3:0] ep, input logic [7:0] em);
    checks++;
    if (out_code !== ec || out_pd_en !== ep || out_pd_mode !== em) begin
      failures++;
      $display("FAIL R%0d actual code=%h pd=%b mode=%h expected code=%h pd=%b mode=%h",
               req, out_code, out_pd_en, out_pd_mode, ec, ep, em);
    end
  endtask

  task automatic send(input logic [1:0] ld, input logic [1:0] sel, input logic pd, input logic [15:0] pay);
    @(negedge clk);
    frm_vld = 1'b1; ld_code = ld; ch_sel = sel; pd_flag = pd; payload = pay;
    @(negedge clk);
    frm_vld = 1'b0;
  endtask

  initial begin
    #1;
    check_out(1, '0, '0, '0); // R1 during reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_out(1, '0, '0, '0); // R1 after release

    for (int k = 0; k < NV; k++) begin
      send(VECS[k].ld, VECS[k].sel, VECS[k].pd, VECS[k].pay);
      check_out(int'(VECS[k].req), VECS[k].e_code, VECS[k].e_pd, VECS[k].e_mode);
    end

    // R10: fields toggle without the strobe
    @(negedge clk);
    ld_code = 2'b11; ch_sel = 2'd3; pd_flag = 1'b0; payload = 16'h1234;
    repeat (3) @(negedge clk);
    check_out(10, 64'h7777_5A5A_0001_FFFF, 4'b0100, 8'h30);

    // R7: mode 01 on channel 3 keeps its code
    send(2'b01, 2'd3, 1'b1, 16'h4000);
    check_out(7, 64'h7777_5A5A_0001_FFFF, 4'b1100, 8'h70);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_out(1, '0, '0, '0);
    rst_n = 1'b1;
    // R1/R5: staged values were cleared too, so a promotion yields zeros
    send(2'b11, 2'd0, 1'b0, 16'hFFFF);
    check_out(1, '0, '0, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule